// File: doc/BRIEF.md
# Lockable configuration register bank

This block is the register file that sits behind an already-decoded serial register port. Each cycle the port may present an 8-bit address with a write strobe and write data, or with a read strobe. One clock after a read strobe the bank returns the addressed byte on its read-data output. The decoded control fields leave the block as plain outputs: a lookup-table enable, an output edge-rate select, six dither controls, a dither parameter byte and a lane-count code. Three per-colour lookup memories, each 256 bytes, are loaded and read back indirectly. Each colour has one address register and one data register. A data write stores the byte at the current address and then advances that address.

Access is gated at two levels. An access state machine has three states. `ST_CLOSED` is the reset state, in which only the device-select location is honoured. `ST_LOCKED` means access is open but the guarded group is protected. `ST_UNLOCKED` means access is open and the guarded group is writable. The transitions are:
- *open*: `ST_CLOSED` to `ST_LOCKED` or `ST_UNLOCKED`, on writing 0xFF to 0x7F. The target depends on the stored unlock bit.
- *close*: `ST_LOCKED` or `ST_UNLOCKED` to `ST_CLOSED`, on writing any other value to 0x7F.
- *unlock*: `ST_LOCKED` to `ST_UNLOCKED`, on writing 0x00 with bit 4 set.
- *lock*: `ST_UNLOCKED` to `ST_LOCKED`, on writing 0x00 with bit 4 clear.

In every other case the state holds.

Top module: `cfg_regbank`

## Requirements
- R1: After reset the outputs take these values:
  - lut_enable = 0 and slow_edge = 0.
  - The dither controls decode 0x61: dith_bypass = 1, dith_de_inv = 0, dith_vs_inv = 0, dith_transpose = 0, dith_temporal = 1, dith_amp3 = 1.
  - dith_param = 0x67 and lane_code = 3'b010.
  - Access starts closed.
- R2: Writing 0xFF to 0x7F opens access, and writing any value from 0x00 to 0xFE to 0x7F closes it. While access is closed, writes to every other address are ignored and reads return 0x00. While access is open, a read of 0x7F returns 0xFF.
- R3: In register 0x00, bit 0 drives lut_enable and bit 4 is the unlock bit (1 = unlocked). A read of 0x00 returns those two bits, with all other bits read as 0.
- R4: Registers 0x01, 0x08, 0x09 and 0x0A take writes only while the unlock bit is 1. A write to any of them while locked leaves it unchanged.
- R5: Bit 4 of register 0x01 drives slow_edge (1 = slow edge). A read of 0x01 returns only that bit.
- R6: Register 0x08 drives the dither controls:
  - bit 0 drives dith_bypass and bit 1 drives dith_de_inv;
  - bit 2 drives dith_vs_inv and bit 4 drives dith_transpose;
  - bit 5 drives dith_temporal and bit 6 drives dith_amp3.
  
  Bits 3 and 7 are not stored and read as 0. Register 0x09 drives dith_param as a full byte.
- R7: Register 0x0A bits [2:0] drive lane_code, where 3'b010 means 2 lanes and 3'b100 means 3 lanes. A read of 0x0A returns 0x00.
- R8: The address/data pairs are 0x02/0x03 for red, 0x04/0x05 for green and 0x06/0x07 for blue. A data write stores the byte at the current colour address, then increments that address, wrapping from 255 to 0. Reading an address register returns its current value.
- R9: A read of a colour data register returns the entry at the current colour address, and does not change that address.
- R10: Writes to reserved addresses (0x0B to 0x7E) change nothing. Reads of reserved addresses return 0x00.
- R11: rd_data changes only on the clock edge that samples rd_en, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Read data, registered one cycle after rd_en |
| lut_enable | output | 1 | Lookup table enable |
| slow_edge | output | 1 | Slow output edge-rate select |
| dith_bypass | output | 1 | Dither bypass |
| dith_de_inv | output | 1 | Invert DE polarity at the dither input |
| dith_vs_inv | output | 1 | Invert VS polarity at the dither input |
| dith_transpose | output | 1 | Transposed pattern on alternate frames |
| dith_temporal | output | 1 | Temporal dithering enable |
| dith_amp3 | output | 1 | 3-bit dither amplitude (0 = 4-bit) |
| dith_param | output | 8 | Dither parameter byte |
| lane_code | output | 3 | Lane-count code |

## Verification
The assertions check these properties on every cycle:
- a device-select write sends the access state machine to the matching open or closed state;
- a write while closed, a write to a reserved address and a locked write to a guarded register leave the decoded outputs untouched;
- rd_data holds between reads;
- a colour address moves only on a write to its own address or data register.

Only the bench scenarios can show that bytes written to the lookup memories come back at the right entries, including across the 255-to-0 wrap. The same holds for the bit positions of each field on read-back, and for the unlock bit surviving a close and reopen of access.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
    localparam int unsigned DW = 8;

    typedef enum logic [1:0] {
        ST_CLOSED   = 2'd0,
        ST_LOCKED   = 2'd1,
        ST_UNLOCKED = 2'd2
    } acc_state_t;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_EDGE   = 8'h01;
    localparam logic [7:0] A_LUTB   = 8'h02;  // first colour address register
    localparam logic [7:0] A_DITH   = 8'h08;
    localparam logic [7:0] A_DPAR   = 8'h09;
    localparam logic [7:0] A_LANE   = 8'h0A;
    localparam logic [7:0] A_RSV_LO = 8'h0B;
    localparam logic [7:0] A_RSV_HI = 8'h7E;
    localparam logic [7:0] A_DEVSEL = 8'h7F;

    localparam logic [7:0] OPEN_KEY  = 8'hFF;
    localparam logic [7:0] DITH_DEF  = 8'h61;
    localparam logic [7:0] DITH_MASK = 8'h77;
    localparam logic [7:0] DPAR_DEF  = 8'h67;
    localparam logic [2:0] LANE_DEF  = 3'b010;

    localparam int unsigned N_COLOURS = 3;
endpackage

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfg_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    input  logic       unlock_q,
    output acc_state_t state,
    output logic       acc_open,
    output logic       acc_unlocked
);
    acc_state_t state_q, state_d;
    logic dev_wr, ctrl_wr, key_ok;

    assign dev_wr  = wr_en && (addr == A_DEVSEL);
    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign key_ok  = (wr_data == OPEN_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLOSED: begin
                if (dev_wr && key_ok) state_d = unlock_q ? ST_UNLOCKED : ST_LOCKED;
            end
            ST_LOCKED: begin
                if (dev_wr && !key_ok)        state_d = ST_CLOSED;
                else if (ctrl_wr && wr_data[4]) state_d = ST_UNLOCKED;
            end
            ST_UNLOCKED: begin
                if (dev_wr && !key_ok)         state_d = ST_CLOSED;
                else if (ctrl_wr && !wr_data[4]) state_d = ST_LOCKED;
            end
            default: state_d = ST_CLOSED;
        endcase
    end

    always_comb begin
        acc_open     = 1'b0;
        acc_unlocked = 1'b0;
        unique case (state_q)
            ST_CLOSED:   ;
            ST_LOCKED:   acc_open = 1'b1;
            ST_UNLOCKED: begin acc_open = 1'b1; acc_unlocked = 1'b1; end
            default:     ;
        endcase
    end

    assign state = state_q;

    // R2
    devsel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && !key_ok) |=> (state_q == ST_CLOSED));
    // R2
    devsel_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && key_ok) |=> (state_q != ST_CLOSED));
endmodule

// File: rtl/cfg_lut_port.sv
module cfg_lut_port #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          data_we,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] entry
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (data_we) mem[addr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_we) addr_q <= wr_data[AW-1:0];
        else if (data_we) addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end

    assign cur_addr = addr_q;
    assign entry    = mem[addr_q];

    // R8
    lut_addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !data_we) |=> $stable(cur_addr));
    // R9
    lut_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !data_we) |=> $stable(entry));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int unsigned LUT_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       lut_enable,
    output logic       slow_edge,
    output logic       dith_bypass,
    output logic       dith_de_inv,
    output logic       dith_vs_inv,
    output logic       dith_transpose,
    output logic       dith_temporal,
    output logic       dith_amp3,
    output logic [7:0] dith_param,
    output logic [2:0] lane_code
);
    localparam int unsigned LAW = $clog2(LUT_DEPTH);

    acc_state_t acc_state;
    logic acc_open, acc_unlocked;
    logic lut_q, unlock_q, edge_q;
    logic [7:0] dith_q, dpar_q, rd_val;
    logic [2:0] lane_q;
    logic wr_ok, g_ok;
    logic [LAW-1:0] col_addr  [N_COLOURS];
    logic [DW-1:0]  col_entry [N_COLOURS];

    cfg_access_fsm u_fsm (
        .clk, .rst_n, .wr_en, .addr, .wr_data, .unlock_q,
        .state(acc_state), .acc_open, .acc_unlocked
    );

    assign wr_ok = wr_en && acc_open;
    assign g_ok  = wr_ok && acc_unlocked;

    for (genvar c = 0; c < N_COLOURS; c++) begin : g_col
        localparam logic [7:0] A_ADR = A_LUTB + 8'(2 * c);
        localparam logic [7:0] A_DAT = A_ADR + 8'd1;
        cfg_lut_port #(.DEPTH(LUT_DEPTH), .AW(LAW), .DW(DW)) u_lut (
            .clk, .rst_n,
            .addr_we (wr_ok && (addr == A_ADR)),
            .data_we (wr_ok && (addr == A_DAT)),
            .wr_data,
            .cur_addr(col_addr[c]),
            .entry   (col_entry[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lut_q    <= 1'b0;
            unlock_q <= 1'b0;
            edge_q   <= 1'b0;
            dith_q   <= DITH_DEF;
            dpar_q   <= DPAR_DEF;
            lane_q   <= LANE_DEF;
        end else if (wr_ok) begin
            unique case (addr)
                A_CTRL: begin
                    lut_q    <= wr_data[0];
                    unlock_q <= wr_data[4];
                end
                A_EDGE: if (g_ok) edge_q <= wr_data[4];
                A_DITH: if (g_ok) dith_q <= wr_data & DITH_MASK;
                A_DPAR: if (g_ok) dpar_q <= wr_data;
                A_LANE: if (g_ok) lane_q <= wr_data[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = 8'h00;
        unique case (addr)
            A_CTRL:   rd_val = {3'b000, unlock_q, 3'b000, lut_q};
            A_EDGE:   rd_val = {3'b000, edge_q, 4'b0000};
            8'h02:    rd_val = 8'(col_addr[0]);
            8'h03:    rd_val = col_entry[0];
            8'h04:    rd_val = 8'(col_addr[1]);
            8'h05:    rd_val = col_entry[1];
            8'h06:    rd_val = 8'(col_addr[2]);
            8'h07:    rd_val = col_entry[2];
            A_DITH:   rd_val = dith_q;
            A_DPAR:   rd_val = dpar_q;
            A_DEVSEL: rd_val = OPEN_KEY;
            default:  rd_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= acc_open ? rd_val : 8'h00;
    end

    assign lut_enable     = lut_q;
    assign slow_edge      = edge_q;
    assign dith_bypass    = dith_q[0];
    assign dith_de_inv    = dith_q[1];
    assign dith_vs_inv    = dith_q[2];
    assign dith_transpose = dith_q[4];
    assign dith_temporal  = dith_q[5];
    assign dith_amp3      = dith_q[6];
    assign dith_param     = dpar_q;
    assign lane_code      = lane_q;

    logic [18:0] ctl_bus;
    assign ctl_bus = {lut_enable, slow_edge, dith_bypass, dith_de_inv, dith_vs_inv,
                      dith_transpose, dith_temporal, dith_amp3, dith_param, lane_code};

    // R4
    locked_dpar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state != ST_UNLOCKED && wr_en && addr == A_DPAR) |=> $stable(dith_param));
    // R4
    locked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state != ST_UNLOCKED && wr_en && addr == A_LANE) |=> $stable(lane_code));
    // R2
    closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state == ST_CLOSED && wr_en && addr != A_DEVSEL) |=> $stable(ctl_bus));
    // R2
    closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state == ST_CLOSED && rd_en) |=> (rd_data == 8'h00));
    // R10
    reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= A_RSV_LO && addr <= A_RSV_HI) |=> $stable(ctl_bus));
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] addr = 8'h00, wr_data = 8'h00;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data, dith_param;
    logic lut_enable, slow_edge, dith_bypass, dith_de_inv, dith_vs_inv;
    logic dith_transpose, dith_temporal, dith_amp3;
    logic [2:0] lane_code;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sb_q[$];
    logic rd_seen = 1'b0;

    always #2 clk = ~clk;

    cfg_regbank u_dut (
        .clk, .rst_n, .addr, .wr_en, .wr_data, .rd_en, .rd_data,
        .lut_enable, .slow_edge, .dith_bypass, .dith_de_inv, .dith_vs_inv,
        .dith_transpose, .dith_temporal, .dith_amp3, .dith_param, .lane_code
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        exp_t e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (sb_q.size() == 0) begin
                    check("monitor: unexpected read", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, rd_data, e.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 lut_enable", lut_enable, 0);
        check("R1 slow_edge", slow_edge, 0);
        check("R1 dither fields", {dith_amp3, dith_temporal, dith_transpose,
              dith_vs_inv, dith_de_inv, dith_bypass}, 6'b110001);
        check("R1 dith_param", dith_param, 8'h67);
        check("R1 lane_code", lane_code, 3'b010);
        check("R1 rd_data", rd_data, 0);
        // R2 closed: reads zero, writes ignored
        rd(8'h08, 8'h00, "R2 read while closed");
        wr(8'h00, 8'h11);
        check("R2 closed write lut_enable", lut_enable, 0);
        wr(8'h03, 8'h99);
        wr(8'h7F, 8'hFF);
        rd(8'h00, 8'h00, "R2 closed write to 0x00 ignored");
        rd(8'h02, 8'h00, "R2 closed write to 0x03 ignored");
        rd(8'h7F, 8'hFF, "R2 device select reads open");
        rd(8'h08, 8'h61, "R1 dither default");
        rd(8'h09, 8'h67, "R1 param default");
        // R4 locked guarded writes
        wr(8'h08, 8'h00); wr(8'h09, 8'h12); wr(8'h0A, 8'h04); wr(8'h01, 8'h10);
        rd(8'h08, 8'h61, "R4 locked 0x08");
        rd(8'h09, 8'h67, "R4 locked 0x09");
        check("R4 locked lane_code", lane_code, 3'b010);
        check("R4 locked slow_edge", slow_edge, 0);
        // R3 control register
        wr(8'h00, 8'hFF);
        rd(8'h00, 8'h11, "R3 ctrl readback");
        check("R3 lut_enable", lut_enable, 1);
        // R5 edge
        wr(8'h01, 8'hFF);
        check("R5 slow_edge", slow_edge, 1);
        rd(8'h01, 8'h10, "R5 edge readback");
        // R6 dither
        wr(8'h08, 8'hFE);
        rd(8'h08, 8'h76, "R6 dither readback masked");
        check("R6 dither fields set", {dith_amp3, dith_temporal, dith_transpose,
              dith_vs_inv, dith_de_inv, dith_bypass}, 6'b111110);
        wr(8'h08, 8'h09);
        check("R6 dither fields bypass only", {dith_amp3, dith_temporal, dith_transpose,
              dith_vs_inv, dith_de_inv, dith_bypass}, 6'b000001);
        wr(8'h09, 8'hA5);
        rd(8'h09, 8'hA5, "R6 param readback");
        check("R6 dith_param", dith_param, 8'hA5);
        // R7 lane
        wr(8'h0A, 8'h04);
        check("R7 lane_code", lane_code, 3'b100);
        rd(8'h0A, 8'h00, "R7 write-only reads zero");
        // R8 load with wrap
        wr(8'h02, 8'hFE);
        wr(8'h03, 8'h11); wr(8'h03, 8'h22); wr(8'h03, 8'h33);
        rd(8'h02, 8'h01, "R8 red address wrapped");
        wr(8'h02, 8'hFE);
        rd(8'h03, 8'h11, "R9 red entry 0xFE");
        rd(8'h03, 8'h11, "R9 read does not advance");
        rd(8'h02, 8'hFE, "R9 address unchanged by read");
        wr(8'h02, 8'hFF);
        rd(8'h03, 8'h22, "R8 red entry 0xFF");
        wr(8'h02, 8'h00);
        rd(8'h03, 8'h33, "R8 red entry 0x00 after wrap");
        wr(8'h04, 8'h10); wr(8'h05, 8'hAA);
        wr(8'h06, 8'h10); wr(8'h07, 8'h55);
        rd(8'h04, 8'h11, "R8 green address advanced");
        wr(8'h04, 8'h10);
        rd(8'h05, 8'hAA, "R8 green entry");
        wr(8'h06, 8'h10);
        rd(8'h07, 8'h55, "R8 blue entry");
        rd(8'h02, 8'h00, "R8 red address untouched by others");
        // R10 reserved
        wr(8'h0B, 8'hFF); wr(8'h16, 8'hFF); wr(8'h7E, 8'h00);
        check("R10 outputs after reserved writes",
              {lut_enable, slow_edge, dith_param, lane_code}, {1'b1, 1'b1, 8'hA5, 3'b100});
        rd(8'h16, 8'h00, "R10 reserved read");
        rd(8'h7F, 8'hFF, "R10 0x7E write kept access open");
        // R4 lock again
        wr(8'h00, 8'h01);
        wr(8'h09, 8'h00);
        rd(8'h09, 8'hA5, "R4 relocked 0x09");
        // R2 close, ignore, reopen
        wr(8'h7F, 8'h5A);
        rd(8'h00, 8'h00, "R2 read after close");
        wr(8'h00, 8'h10);
        wr(8'h02, 8'h44);
        wr(8'h7F, 8'hFF);
        rd(8'h00, 8'h01, "R2 ctrl unchanged across close");
        rd(8'h02, 8'h00, "R2 colour address unchanged across close");
        // R11 hold
        repeat (3) @(negedge clk);
        check("R11 rd_data holds", rd_data, 8'h00);
        rd(8'h09, 8'hA5, "R11 new read");
        repeat (3) @(negedge clk);
        check("R11 rd_data holds after read", rd_data, 8'hA5);
        check("R11 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule